// File: doc/BRIEF.md
# Dynamic-access memory sequencer

This block connects a processing datapath to a set of single-port memory banks. Every cycle it executes one entry of a schedule that is fixed when the block is built. An entry can hold a static access, whose bank, address and direction are known in advance, and it can also open a dynamic access. For a dynamic access the datapath computes an element index at run time and sends it over one of the shared data buses. The buses carry plain data words. The schedule alone decides, by time slot, which bus word is an index, which is write data and which bus receives returned read data.

A built-in translation table turns the logical index of an array into a bank number and a physical address. Arrays can be split across banks so that neighbouring elements sit in different banks. A parameter selects between an interleaved and a blocked placement. In a cycle that carries a dynamic access, every bank holding part of the target array is reserved. A static entry aimed at a reserved bank is dropped and the drop is recorded. Bank reads return their data one cycle after the address is presented.

Top module: `dyn_mem_seq`

## Requirements
- R1: After reset, or while reset is held, every `dp_rvalid_o` bit, `dp_rdata_o`, `conflict_o` and `oor_o` are 0, all bank contents read as 0, and no bank access takes place until `start_i` has been seen.
- R2: A cycle with `start_i` high issues no access, clears both sticky flags and sets the schedule to entry 0. From the following cycle on, one entry is executed per cycle. After the last entry it wraps back to entry 0.
- R3: A schedule entry is packed with its LSB first, using the default widths: bit 0 static valid, bit 1 static write, [3:2] static bank, [7:4] static address, [8] static bus, [9] dynamic valid, [10] dynamic write, [11] target array, [12] index bus, [13] data bus. Entry k occupies bits [14k+13:14k] of `SCHED_TBL`.
- R4: A static write stores the word on its selected bus into its bank and address. A static read puts that bank word on its selected bus in the next cycle, with the matching `dp_rvalid_o` bit high.
- R5: With interleaved placement, index i of array a maps to bank a*(N_BANKS/N_ARR) + i mod (N_BANKS/N_ARR) and to address i div (N_BANKS/N_ARR). The index is the whole word on the entry's index bus.
- R6: A dynamic write stores the word on the entry's data bus at the translated bank and address.
- R7: A dynamic read returns the translated word on the entry's data bus in the next cycle, with the matching valid bit high.
- R8: While a dynamic access is active, every bank of its target array is reserved. A static entry aimed at a reserved bank performs no access and sets `conflict_o`. The flag stays set until the next `start_i` or reset.
- R9: A dynamic index of ARR_LEN or more causes no bank access and no returned data. It sets `oor_o`, which stays set until the next `start_i` or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Restart the schedule from entry 0 |
| dp_wdata_i | input | N_BUS*DW | Words sent from the datapath, one per bus |
| dp_rdata_o | output | N_BUS*DW | Returned read data, one word per bus |
| dp_rvalid_o | output | N_BUS | Returned data valid, one bit per bus |
| conflict_o | output | 1 | Sticky: a static entry was dropped because its bank was reserved |
| oor_o | output | 1 | Sticky: a dynamic index was outside the array |

## Verification
The bench builds the block with four banks of sixteen words, two buses, two arrays of eight elements, interleaved placement, and an eight-entry schedule that it supplies itself. With these values the first array lives in banks 0 and 1 and the second in banks 2 and 3. One schedule therefore covers all of the following: a static read in a bank next to a locked array, a static read that runs into a lock, an index past the array end, and even and odd indices landing in different banks. Running the schedule twice with different bus words exercises the wrap to entry 0 and shows that the sticky flags hold across passes.

// File: rtl/dms_pkg.sv
package dms_pkg;
  typedef enum logic {MAP_INTERLEAVE = 1'b0, MAP_BLOCK = 1'b1} map_mode_e;

  function automatic int w_of(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // entry = 4 flag bits + bank + addr + three bus selects + array id
  function automatic int entry_w(input int n_banks, input int depth,
                                 input int n_bus, input int n_arr);
    return 4 + w_of(n_banks) + w_of(depth) + 3 * w_of(n_bus) + w_of(n_arr);
  endfunction
endpackage

// File: rtl/dms_sched.sv
module dms_sched #(
  parameter int SCHED_LEN = 8,
  parameter int BANK_W    = 2,
  parameter int ADDR_W    = 4,
  parameter int BUS_W     = 1,
  parameter int ARR_W     = 1,
  parameter int SE_W      = 4 + BANK_W + ADDR_W + 3 * BUS_W + ARR_W,
  parameter logic [SCHED_LEN*SE_W-1:0] SCHED_TBL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              st_v_o,
  output logic              st_we_o,
  output logic [BANK_W-1:0] st_bank_o,
  output logic [ADDR_W-1:0] st_addr_o,
  output logic [BUS_W-1:0]  st_bus_o,
  output logic              dy_v_o,
  output logic              dy_we_o,
  output logic [ARR_W-1:0]  dy_arr_o,
  output logic [BUS_W-1:0]  dy_ibus_o,
  output logic [BUS_W-1:0]  dy_dbus_o
);
  localparam int STEP_W = dms_pkg::w_of(SCHED_LEN);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(SCHED_LEN - 1);
  localparam int O_SWE  = 1;
  localparam int O_SBK  = 2;
  localparam int O_SAD  = O_SBK + BANK_W;
  localparam int O_SBUS = O_SAD + ADDR_W;
  localparam int O_DV   = O_SBUS + BUS_W;
  localparam int O_DWE  = O_DV + 1;
  localparam int O_ARR  = O_DWE + 1;
  localparam int O_IBUS = O_ARR + ARR_W;
  localparam int O_DBUS = O_IBUS + BUS_W;

  logic [STEP_W-1:0] step_q;
  logic              run_q;
  logic              issue;
  logic [SE_W-1:0]   ent;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      run_q  <= 1'b0;
    end else if (start_i) begin
      step_q <= '0;
      run_q  <= 1'b1;
    end else if (run_q) begin
      step_q <= (step_q == LAST) ? '0 : step_q + 1'b1;
    end
  end

  // the start cycle itself issues nothing
  assign issue = run_q & ~start_i;
  assign ent   = SCHED_TBL[step_q*SE_W +: SE_W];

  assign st_v_o    = issue & ent[0];
  assign st_we_o   = ent[O_SWE];
  assign st_bank_o = ent[O_SBK +: BANK_W];
  assign st_addr_o = ent[O_SAD +: ADDR_W];
  assign st_bus_o  = ent[O_SBUS +: BUS_W];
  assign dy_v_o    = issue & ent[O_DV];
  assign dy_we_o   = ent[O_DWE];
  assign dy_arr_o  = ent[O_ARR +: ARR_W];
  assign dy_ibus_o = ent[O_IBUS +: BUS_W];
  assign dy_dbus_o = ent[O_DBUS +: BUS_W];

  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !start_i && step_q == LAST) |=> (step_q == '0));
  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (run_q && step_q == '0));
endmodule

// File: rtl/dms_xlat.sv
module dms_xlat #(
  parameter int N_BANKS = 4,
  parameter int N_ARR   = 2,
  parameter int ARR_LEN = 8,
  parameter int DW      = 16,
  parameter int BANK_W  = 2,
  parameter int ADDR_W  = 4,
  parameter int ARR_W   = 1,
  parameter dms_pkg::map_mode_e MAP_MODE = dms_pkg::MAP_INTERLEAVE
) (
  input  logic               dy_v_i,
  input  logic [ARR_W-1:0]   arr_i,
  input  logic [DW-1:0]      idx_i,
  output logic               hit_o,
  output logic [BANK_W-1:0]  bank_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [N_BANKS-1:0] lock_o,
  output logic               oor_o
);
  localparam int BPA   = N_BANKS / N_ARR;
  localparam int EPB   = (ARR_LEN + BPA - 1) / BPA;
  localparam int IDX_W = dms_pkg::w_of(ARR_LEN);

  logic [BANK_W-1:0]  tb_bank [N_ARR][ARR_LEN];
  logic [ADDR_W-1:0]  tb_addr [N_ARR][ARR_LEN];
  logic [N_BANKS-1:0] mask    [N_ARR];
  logic               in_range;
  logic [IDX_W-1:0]   li;

  for (genvar a = 0; a < N_ARR; a++) begin : g_arr
    for (genvar i = 0; i < ARR_LEN; i++) begin : g_el
      if (MAP_MODE == dms_pkg::MAP_INTERLEAVE) begin : g_il
        assign tb_bank[a][i] = BANK_W'(a * BPA + i % BPA);
        assign tb_addr[a][i] = ADDR_W'(i / BPA);
      end else begin : g_blk
        assign tb_bank[a][i] = BANK_W'(a * BPA + i / EPB);
        assign tb_addr[a][i] = ADDR_W'(i % EPB);
      end
    end
  end

  // banks owned by each array, derived from the table
  always_comb begin
    for (int a = 0; a < N_ARR; a++) begin
      mask[a] = '0;
      for (int i = 0; i < ARR_LEN; i++) mask[a][tb_bank[a][i]] = 1'b1;
    end
  end

  assign in_range = idx_i < DW'(ARR_LEN);
  assign li       = idx_i[IDX_W-1:0];
  assign hit_o    = dy_v_i & in_range;
  assign oor_o    = dy_v_i & ~in_range;
  assign bank_o   = tb_bank[arr_i][li];
  assign addr_o   = tb_addr[arr_i][li];
  assign lock_o   = dy_v_i ? mask[arr_i] : '0;
endmodule

// File: rtl/dms_xbar.sv
module dms_xbar #(
  parameter int N_BANKS = 4,
  parameter int N_BUS   = 2,
  parameter int DW      = 16,
  parameter int BANK_W  = 2,
  parameter int ADDR_W  = 4,
  parameter int BUS_W   = 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_BUS-1:0][DW-1:0]       bus_i,
  input  logic                           st_v_i,
  input  logic                           st_we_i,
  input  logic [BANK_W-1:0]              st_bank_i,
  input  logic [ADDR_W-1:0]              st_addr_i,
  input  logic [BUS_W-1:0]               st_bus_i,
  input  logic [N_BANKS-1:0]             lock_i,
  input  logic                           dy_hit_i,
  input  logic                           dy_we_i,
  input  logic [BANK_W-1:0]              dy_bank_i,
  input  logic [ADDR_W-1:0]              dy_addr_i,
  input  logic [BUS_W-1:0]               dy_dbus_i,
  input  logic [N_BANKS-1:0][DW-1:0]     bank_rdata_i,
  output logic [N_BANKS-1:0]             bk_en_o,
  output logic [N_BANKS-1:0]             bk_we_o,
  output logic [N_BANKS-1:0][ADDR_W-1:0] bk_addr_o,
  output logic [N_BANKS-1:0][DW-1:0]     bk_wdata_o,
  output logic                           st_blk_o,
  output logic [N_BUS-1:0][DW-1:0]       rdata_o,
  output logic [N_BUS-1:0]               rvalid_o
);
  logic               st_go;
  logic [N_BANKS-1:0] st_sel, dy_sel;
  logic               st_rd_q, dy_rd_q;
  logic [BANK_W-1:0]  st_rbk_q, dy_rbk_q;
  logic [BUS_W-1:0]   st_rbus_q, dy_rbus_q;
  logic [N_BUS-1:0]   st_ret, dy_ret;

  assign st_blk_o = st_v_i & lock_i[st_bank_i];
  assign st_go    = st_v_i & ~lock_i[st_bank_i];

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    assign st_sel[b]     = st_go && (st_bank_i == BANK_W'(b));
    assign dy_sel[b]     = dy_hit_i && (dy_bank_i == BANK_W'(b));
    assign bk_en_o[b]    = st_sel[b] | dy_sel[b];
    assign bk_we_o[b]    = dy_sel[b] ? dy_we_i : st_we_i;
    assign bk_addr_o[b]  = dy_sel[b] ? dy_addr_i : st_addr_i;
    assign bk_wdata_o[b] = dy_sel[b] ? bus_i[dy_dbus_i] : bus_i[st_bus_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_rd_q   <= 1'b0;
      dy_rd_q   <= 1'b0;
      st_rbk_q  <= '0;
      dy_rbk_q  <= '0;
      st_rbus_q <= '0;
      dy_rbus_q <= '0;
    end else begin
      st_rd_q   <= st_go & ~st_we_i;
      dy_rd_q   <= dy_hit_i & ~dy_we_i;
      st_rbk_q  <= st_bank_i;
      dy_rbk_q  <= dy_bank_i;
      st_rbus_q <= st_bus_i;
      dy_rbus_q <= dy_dbus_i;
    end
  end

  // dynamic return wins a shared bus slot
  for (genvar u = 0; u < N_BUS; u++) begin : g_ret
    assign dy_ret[u]   = dy_rd_q && (dy_rbus_q == BUS_W'(u));
    assign st_ret[u]   = st_rd_q && (st_rbus_q == BUS_W'(u));
    assign rvalid_o[u] = dy_ret[u] | st_ret[u];
    assign rdata_o[u]  = dy_ret[u] ? bank_rdata_i[dy_rbk_q] :
                         st_ret[u] ? bank_rdata_i[st_rbk_q] : '0;
  end

  p_one_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_sel & dy_sel) == '0);
endmodule

// File: rtl/dms_bank.sv
module dms_bank #(
  parameter int DW     = 16,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
      rdata_q <= '0;
    end else if (en_i) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      else      rdata_q       <= mem_q[addr_i];
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/dyn_mem_seq.sv
module dyn_mem_seq #(
  parameter int N_BANKS    = 4,
  parameter int BANK_DEPTH = 16,
  parameter int DW         = 16,
  parameter int N_BUS      = 2,
  parameter int N_ARR      = 2,
  parameter int ARR_LEN    = 8,
  parameter int SCHED_LEN  = 8,
  parameter dms_pkg::map_mode_e MAP_MODE = dms_pkg::MAP_INTERLEAVE,
  parameter logic [SCHED_LEN*dms_pkg::entry_w(N_BANKS, BANK_DEPTH, N_BUS, N_ARR)-1:0]
    SCHED_TBL = '0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [N_BUS-1:0][DW-1:0] dp_wdata_i,
  output logic [N_BUS-1:0][DW-1:0] dp_rdata_o,
  output logic [N_BUS-1:0]         dp_rvalid_o,
  output logic                     conflict_o,
  output logic                     oor_o
);
  localparam int BANK_W = dms_pkg::w_of(N_BANKS);
  localparam int ADDR_W = dms_pkg::w_of(BANK_DEPTH);
  localparam int BUS_W  = dms_pkg::w_of(N_BUS);
  localparam int ARR_W  = dms_pkg::w_of(N_ARR);
  localparam int SE_W   = dms_pkg::entry_w(N_BANKS, BANK_DEPTH, N_BUS, N_ARR);

  logic              st_v, st_we, dy_v, dy_we;
  logic [BANK_W-1:0] st_bank, dy_bank;
  logic [ADDR_W-1:0] st_addr, dy_addr;
  logic [BUS_W-1:0]  st_bus, dy_ibus, dy_dbus;
  logic [ARR_W-1:0]  dy_arr;
  logic              dy_hit, dy_oor, st_blk;
  logic [N_BANKS-1:0] lock, bk_en, bk_we;
  logic [N_BANKS-1:0][ADDR_W-1:0] bk_addr;
  logic [N_BANKS-1:0][DW-1:0]     bk_wdata, bk_rdata;
  logic conf_q, oor_q;

  dms_sched #(
    .SCHED_LEN(SCHED_LEN), .BANK_W(BANK_W), .ADDR_W(ADDR_W), .BUS_W(BUS_W),
    .ARR_W(ARR_W), .SE_W(SE_W), .SCHED_TBL(SCHED_TBL)
  ) u_sched (
    .clk_i, .rst_ni, .start_i,
    .st_v_o(st_v), .st_we_o(st_we), .st_bank_o(st_bank), .st_addr_o(st_addr),
    .st_bus_o(st_bus), .dy_v_o(dy_v), .dy_we_o(dy_we), .dy_arr_o(dy_arr),
    .dy_ibus_o(dy_ibus), .dy_dbus_o(dy_dbus)
  );

  dms_xlat #(
    .N_BANKS(N_BANKS), .N_ARR(N_ARR), .ARR_LEN(ARR_LEN), .DW(DW),
    .BANK_W(BANK_W), .ADDR_W(ADDR_W), .ARR_W(ARR_W), .MAP_MODE(MAP_MODE)
  ) u_xlat (
    .dy_v_i(dy_v), .arr_i(dy_arr), .idx_i(dp_wdata_i[dy_ibus]),
    .hit_o(dy_hit), .bank_o(dy_bank), .addr_o(dy_addr), .lock_o(lock),
    .oor_o(dy_oor)
  );

  dms_xbar #(
    .N_BANKS(N_BANKS), .N_BUS(N_BUS), .DW(DW), .BANK_W(BANK_W),
    .ADDR_W(ADDR_W), .BUS_W(BUS_W)
  ) u_xbar (
    .clk_i, .rst_ni, .bus_i(dp_wdata_i),
    .st_v_i(st_v), .st_we_i(st_we), .st_bank_i(st_bank), .st_addr_i(st_addr),
    .st_bus_i(st_bus), .lock_i(lock), .dy_hit_i(dy_hit), .dy_we_i(dy_we),
    .dy_bank_i(dy_bank), .dy_addr_i(dy_addr), .dy_dbus_i(dy_dbus),
    .bank_rdata_i(bk_rdata), .bk_en_o(bk_en), .bk_we_o(bk_we),
    .bk_addr_o(bk_addr), .bk_wdata_o(bk_wdata), .st_blk_o(st_blk),
    .rdata_o(dp_rdata_o), .rvalid_o(dp_rvalid_o)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_mem
    dms_bank #(.DW(DW), .DEPTH(BANK_DEPTH), .ADDR_W(ADDR_W)) u_bank (
      .clk_i, .rst_ni, .en_i(bk_en[b]), .we_i(bk_we[b]), .addr_i(bk_addr[b]),
      .wdata_i(bk_wdata[b]), .rdata_o(bk_rdata[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conf_q <= 1'b0;
      oor_q  <= 1'b0;
    end else if (start_i) begin
      conf_q <= 1'b0;
      oor_q  <= 1'b0;
    end else begin
      conf_q <= conf_q | st_blk;
      oor_q  <= oor_q | dy_oor;
    end
  end

  assign conflict_o = conf_q;
  assign oor_o      = oor_q;

  p_rvalid_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bk_en == '0) |=> (dp_rvalid_o == '0));
  p_oor_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dy_oor && !st_v) |-> (bk_en == '0));
  p_conf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conflict_o && !start_i) |=> conflict_o);
  p_oor_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oor_o && !start_i) |=> oor_o);
endmodule

// File: tb/dyn_mem_seq_test.sv
`timescale 1ns/1ps
module dyn_mem_seq_test;
  localparam int SE_W = 14;
  localparam int NV   = 16;

  function automatic logic [SE_W-1:0] ent(
      input logic sv, input logic swe, input logic [1:0] sbk, input logic [3:0] sad,
      input logic sbus, input logic dv, input logic dwe, input logic arr,
      input logic ibus, input logic dbus);
    return {dbus, ibus, arr, dwe, dv, sbus, sad, sbk, swe, sv};
  endfunction

  function automatic logic [8*SE_W-1:0] build_tbl();
    logic [8*SE_W-1:0] t;
    t = '0;
    t[0*SE_W +: SE_W] = ent(1, 1, 2'd0, 4'd3, 0, 0, 0, 0, 0, 0);
    t[1*SE_W +: SE_W] = ent(1, 1, 2'd2, 4'd2, 1, 0, 0, 0, 0, 0);
    t[2*SE_W +: SE_W] = ent(1, 0, 2'd0, 4'd3, 0, 0, 0, 0, 0, 0);
    t[3*SE_W +: SE_W] = ent(1, 0, 2'd2, 4'd2, 1, 1, 1, 0, 0, 1);
    t[4*SE_W +: SE_W] = ent(1, 0, 2'd1, 4'd0, 0, 1, 0, 0, 0, 1);
    t[5*SE_W +: SE_W] = ent(0, 0, 2'd0, 4'd0, 0, 1, 0, 1, 0, 0);
    t[6*SE_W +: SE_W] = ent(0, 0, 2'd0, 4'd0, 0, 1, 0, 1, 0, 0);
    return t;
  endfunction

  localparam logic [8*SE_W-1:0] TBL = build_tbl();

  typedef struct packed {
    logic [15:0] b0, b1;
    logic v0; logic [15:0] d0;
    logic v1; logic [15:0] d1;
    logic cf, oo;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{16'hA5A5, 16'h0000, 0, 16'h0000, 0, 16'h0000, 0, 0},
    '{16'h0000, 16'h1234, 0, 16'h0000, 0, 16'h0000, 0, 0},
    '{16'h0000, 16'h0000, 1, 16'hA5A5, 0, 16'h0000, 0, 0},
    '{16'h0006, 16'hBEEF, 0, 16'h0000, 1, 16'h1234, 0, 0},
    '{16'h0006, 16'h0000, 0, 16'h0000, 1, 16'hBEEF, 1, 0},
    '{16'h0009, 16'h0000, 0, 16'h0000, 0, 16'h0000, 1, 1},
    '{16'h0004, 16'h0000, 1, 16'h1234, 0, 16'h0000, 1, 1},
    '{16'h0000, 16'h0000, 0, 16'h0000, 0, 16'h0000, 1, 1},
    '{16'h0F0F, 16'h0000, 0, 16'h0000, 0, 16'h0000, 1, 1},
    '{16'h0000, 16'h7777, 0, 16'h0000, 0, 16'h0000, 1, 1},
    '{16'h0000, 16'h0000, 1, 16'h0F0F, 0, 16'h0000, 1, 1},
    '{16'h0007, 16'h5A5A, 0, 16'h0000, 1, 16'h7777, 1, 1},
    '{16'h0007, 16'h0000, 0, 16'h0000, 1, 16'h5A5A, 1, 1},
    '{16'h0003, 16'h0000, 1, 16'h0000, 0, 16'h0000, 1, 1},
    '{16'h0004, 16'h0000, 1, 16'h7777, 0, 16'h0000, 1, 1},
    '{16'h0000, 16'h0000, 0, 16'h0000, 0, 16'h0000, 1, 1}
  };

  function automatic string vec_req(input int i);
    case (i)
      0, 1, 2, 9, 10: return "R4";
      3, 11:          return "R6";
      4:              return "R8";
      5:              return "R9";
      6, 13, 14:      return "R5";
      8:              return "R2";
      12:             return "R7";
      default:        return "R3";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [1:0][15:0] wdata = '0;
  logic [1:0][15:0] rdata;
  logic [1:0]       rvalid;
  logic conflict, oor;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 0;

  always #10 clk = ~clk;

  dyn_mem_seq #(.SCHED_TBL(TBL)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .dp_wdata_i(wdata),
    .dp_rdata_o(rdata), .dp_rvalid_o(rvalid), .conflict_o(conflict), .oor_o(oor)
  );

  task automatic chk(input bit ok, input string req, input logic [67:0] act,
                     input logic [67:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [67:0] observe(input vec_t e);
    return {32'h0, rvalid[0], e.v0 ? rdata[0] : 16'h0,
            rvalid[1], e.v1 ? rdata[1] : 16'h0, conflict, oor};
  endfunction

  function automatic logic [67:0] expect_of(input vec_t e);
    return {32'h0, e.v0, e.d0, e.v1, e.d1, e.cf, e.oo};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    vec_t e;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rvalid == 2'b00 && !conflict && !oor && rdata == '0, "R1",
        {64'h0, rvalid, conflict, oor}, 68'h0);
    rst_ni = 1'b1;
    // R1: nothing happens without start
    wdata = {16'h0, 16'hFFFF};
    @(posedge clk); @(negedge clk);
    chk(rvalid == 2'b00 && !conflict && !oor, "R1",
        {64'h0, rvalid, conflict, oor}, 68'h0);

    start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < NV; i++) begin
      e = VEC[i];
      wdata = {e.b1, e.b0};
      @(posedge clk); @(negedge clk);
      chk(observe(e) == expect_of(e), vec_req(i), observe(e), expect_of(e));
    end

    // R2: restart clears flags and resumes at entry 0
    start_i = 1'b1;
    wdata = {16'h0, 16'h2222};
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    chk(!conflict && !oor, "R2", {66'h0, conflict, oor}, 68'h0);
    wdata = {16'h0, 16'h3333};
    @(posedge clk); @(negedge clk);
    wdata = '0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk(rvalid[0] && rdata[0] == 16'h3333, "R2",
        {51'h0, rvalid[0], rdata[0]}, {51'h0, 1'b1, 16'h3333});

    // R1: reset in mid run
    rst_ni = 1'b0;
    #1;
    chk(rvalid == 2'b00 && !conflict && !oor && rdata == '0, "R1",
        {32'h0, rdata, rvalid, conflict, oor}, 68'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    for (int k = 0; k < 3; k++) begin
      wdata = {16'h0, 16'h0001};
      @(posedge clk); @(negedge clk);
      chk(rvalid == 2'b00, "R1", {66'h0, rvalid}, 68'h0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule